// File: doc/BRIEF.md
# Branch Prediction Table

This block is a small direct-mapped table that a fetch stage consults to guess where a branch will go. Every entry keeps a tag from the branch address, the address the branch jumped to last time, and a prediction state. The lookup side is combinational. The fetch address arrives and, in the same cycle, the block answers whether the address is a known branch, whether it is predicted taken, and where it would go.

The update side is registered. When a branch resolves later in the pipeline, its address, its real outcome and its real target are written back. A branch that is already in the table moves its prediction state. A branch that is not in the table takes over the entry at its index.

A parameter picks the prediction scheme. With one state bit, the entry simply remembers the last outcome. With two state bits, the entry is a saturating counter. That counter needs two opposite outcomes in a row before a strong prediction turns around.

Top module: `branch_predict_table`

## Requirements
- R1: While reset is asserted and after it is released, every entry is invalid, so every lookup misses until an update is written.
- R2: An address selects entry `pc[IDX_W+1:2]` (IDX_W = log2 of ENTRIES) and carries tag `pc[ADDR_W-1:IDX_W+2]`. A lookup hits only when the selected entry is valid and its stored tag equals the address tag. An address with the same index but a different tag misses, and entries at different indices do not disturb each other.
- R3: On a miss, `lookupTaken` is 0 (assume not taken) and `lookupTarget` is all zeros.
- R4: With CTR_BITS=2, the state is a counter from 0 to 3 and the prediction is taken when the counter is 2 or 3. A taken outcome increments the counter and saturates at 3. A not-taken outcome decrements it and saturates at 0. A counter never moves by more than one per update, so a strong state needs two consecutive opposite outcomes to flip the prediction.
- R5: With CTR_BITS=1, the state bit equals the last outcome (1 = taken), so every misprediction flips the prediction.
- R6: An update whose address misses allocates the entry. It sets valid, stores the tag and the target, and sets the weak state in the direction of the outcome: 2 for taken and 1 for not taken with two bits, or the outcome itself with one bit.
- R7: An update that hits rewrites the stored target only when the outcome is taken. A not-taken update that hits keeps the old target.
- R8: Updates take effect at the clock edge. A lookup in the same cycle as an update to that entry returns the old contents, and the next cycle returns the new ones. Without an update, the table does not change.
- R9: An allocation at an index held by another tag replaces that entry, and the old branch then misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, clears all valid bits |
| lookupPc | input | ADDR_W | Fetch address to look up |
| lookupHit | output | 1 | Valid entry with matching tag |
| lookupTaken | output | 1 | Predicted direction, 1 = taken |
| lookupTarget | output | ADDR_W | Predicted target, zero on a miss |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | ADDR_W | Address of the resolved branch |
| updTaken | input | 1 | Actual outcome, 1 = taken |
| updTarget | input | ADDR_W | Actual target of the resolved branch |

## Verification
Some properties are checked on every cycle by the assertions:
- The valid bits clear under reset.
- Every write installs the written tag at the written index.
- The table stays still in cycles without an update.
- The counter moves by at most one step and saturates at its top.

Other behaviour only the bench's scenarios can show, because it spans a history of outcomes:
- The two-in-a-row hysteresis of the four-state scheme.
- The single-step flip of the one-bit scheme.
- Target retention on not-taken hits.
- Alias replacement.
- The one-cycle visibility of an update.

// File: rtl/brpred_pkg.sv
package brpred_pkg;
  // Write strobes handed from the control to the storage
  typedef struct packed {
    logic wrEn;        // write this cycle's update into its entry
    logic allocate;    // entry is being taken over by a new branch
    logic loadTarget;  // overwrite the stored target
  } tblStrobe_t;
endpackage

// File: rtl/brpred_ctrl.sv
module brpred_ctrl
  import brpred_pkg::*;
#(
  parameter int CTR_BITS = 2,
  parameter int TAG_W    = 26
) (
  input  logic                updValid,
  input  logic                updTaken,
  input  logic [TAG_W-1:0]    updTag,
  input  logic                entValid,
  input  logic [TAG_W-1:0]    entTag,
  input  logic [CTR_BITS-1:0] entCtr,
  output tblStrobe_t          strobe,
  output logic [CTR_BITS-1:0] nextCtr
);
  logic entMatch;

  assign entMatch          = entValid && (entTag == updTag);
  assign strobe.wrEn       = updValid;
  assign strobe.allocate   = updValid && !entMatch;
  assign strobe.loadTarget = updValid && (!entMatch || updTaken);

  generate
    if (CTR_BITS == 1) begin : g_toggle
      logic unusedCtr;
      assign unusedCtr = entCtr[0];
      assign nextCtr   = updTaken;
    end else begin : g_sat
      localparam logic [CTR_BITS-1:0] CTR_MAX = '1;
      localparam logic [CTR_BITS-1:0] WEAK_T  = CTR_BITS'(1) << (CTR_BITS - 1);
      localparam logic [CTR_BITS-1:0] WEAK_N  = WEAK_T - CTR_BITS'(1);

      always_comb begin
        if (!entMatch)                 nextCtr = updTaken ? WEAK_T : WEAK_N;
        else if (updTaken)             nextCtr = (entCtr == CTR_MAX) ? entCtr : entCtr + CTR_BITS'(1);
        else                           nextCtr = (entCtr == '0) ? entCtr : entCtr - CTR_BITS'(1);
      end

      always_comb begin
        if (strobe.wrEn && entMatch) begin
          p_step_one_r4: assert ((nextCtr == entCtr) || (nextCtr == entCtr + CTR_BITS'(1))
                                 || (nextCtr == entCtr - CTR_BITS'(1)))
            else $error("counter moved by more than one step");
          if (updTaken && entCtr == CTR_MAX)
            p_saturate_r4: assert (nextCtr == CTR_MAX)
              else $error("counter wrapped past its top");
        end
      end
    end
  endgenerate
endmodule

// File: rtl/brpred_store.sv
module brpred_store
  import brpred_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int ADDR_W   = 32,
  parameter int CTR_BITS = 2,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int TAG_W   = ADDR_W - IDX_W - 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   lookupPc,
  output logic                lookupHit,
  output logic                lookupTaken,
  output logic [ADDR_W-1:0]   lookupTarget,
  input  logic [ADDR_W-1:0]   updPc,
  input  logic [ADDR_W-1:0]   updTarget,
  input  tblStrobe_t          strobe,
  input  logic [CTR_BITS-1:0] nextCtr,
  output logic                entValid,
  output logic [TAG_W-1:0]    entTag,
  output logic [CTR_BITS-1:0] entCtr,
  output logic [TAG_W-1:0]    updTag
);
  logic [ENTRIES-1:0]  validQ;
  logic [TAG_W-1:0]    tagQ [ENTRIES];
  logic [ADDR_W-1:0]   tgtQ [ENTRIES];
  logic [CTR_BITS-1:0] ctrQ [ENTRIES];

  logic [IDX_W-1:0] lkIdx, updIdx;
  logic [TAG_W-1:0] lkTag;
  logic             unusedLowBits;

  assign lkIdx  = lookupPc[IDX_W+1:2];
  assign lkTag  = lookupPc[ADDR_W-1:IDX_W+2];
  assign updIdx = updPc[IDX_W+1:2];
  assign updTag = updPc[ADDR_W-1:IDX_W+2];
  assign unusedLowBits = ^{lookupPc[1:0], updPc[1:0]};

  // Lookup port
  assign lookupHit    = validQ[lkIdx] && (tagQ[lkIdx] == lkTag);
  assign lookupTaken  = lookupHit && ctrQ[lkIdx][CTR_BITS-1];
  assign lookupTarget = lookupHit ? tgtQ[lkIdx] : '0;

  // Read of the entry addressed by the update port
  assign entValid = validQ[updIdx];
  assign entTag   = tagQ[updIdx];
  assign entCtr   = ctrQ[updIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            validQ <= '0;
    else if (strobe.wrEn) validQ[updIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      tagQ[updIdx] <= updTag;
      ctrQ[updIdx] <= nextCtr;
      if (strobe.loadTarget) tgtQ[updIdx] <= updTarget;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) !rstN |=> (validQ == '0))
    else $error("valid bits survive reset");

  p_write_installs_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> validQ[$past(updIdx)] && (tagQ[$past(updIdx)] == $past(updTag)))
    else $error("update did not install its tag");

  p_quiet_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(validQ))
    else $error("valid bits changed without an update");
endmodule

// File: rtl/branch_predict_table.sv
module branch_predict_table
  import brpred_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int ADDR_W   = 32,
  parameter int CTR_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookupPc,
  output logic              lookupHit,
  output logic              lookupTaken,
  output logic [ADDR_W-1:0] lookupTarget,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - 2;

  tblStrobe_t          strobe;
  logic [CTR_BITS-1:0] nextCtr, entCtr;
  logic [TAG_W-1:0]    entTag, updTag;
  logic                entValid;

  brpred_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CTR_BITS(CTR_BITS)) uStore (
    .clk(clk), .rstN(rstN),
    .lookupPc(lookupPc), .lookupHit(lookupHit), .lookupTaken(lookupTaken),
    .lookupTarget(lookupTarget),
    .updPc(updPc), .updTarget(updTarget), .strobe(strobe), .nextCtr(nextCtr),
    .entValid(entValid), .entTag(entTag), .entCtr(entCtr), .updTag(updTag)
  );

  brpred_ctrl #(.CTR_BITS(CTR_BITS), .TAG_W(TAG_W)) uCtrl (
    .updValid(updValid), .updTaken(updTaken), .updTag(updTag),
    .entValid(entValid), .entTag(entTag), .entCtr(entCtr),
    .strobe(strobe), .nextCtr(nextCtr)
  );
endmodule

// File: tb/branch_predict_table_test.sv
module branch_predict_table_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lookupPc = '0;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic        updTaken = 1'b0;
  logic [31:0] updTarget = '0;

  logic        hit2, tk2, hit1, tk1;
  logic [31:0] tgt2, tgt1;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  // Four-state scheme
  branch_predict_table #(.ENTRIES(16), .ADDR_W(32), .CTR_BITS(2)) uut (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .lookupHit(hit2),
    .lookupTaken(tk2), .lookupTarget(tgt2), .updValid(updValid),
    .updPc(updPc), .updTaken(updTaken), .updTarget(updTarget));

  // Two-state scheme on the same stimulus
  branch_predict_table #(.ENTRIES(16), .ADDR_W(32), .CTR_BITS(1)) uutOne (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .lookupHit(hit1),
    .lookupTaken(tk1), .lookupTarget(tgt1), .updValid(updValid),
    .updPc(updPc), .updTaken(updTaken), .updTarget(updTarget));

  typedef struct {
    logic        hit;
    logic        taken2;
    logic        taken1;
    logic [31:0] target;
    string       req;
  } expItem_t;

  expItem_t expQ[$];

  localparam logic [31:0] PC_A = 32'h0000_1044;  // index 1
  localparam logic [31:0] PC_B = 32'h0000_2044;  // index 1, other tag
  localparam logic [31:0] PC_C = 32'h0000_1048;  // index 2
  localparam logic [31:0] T1   = 32'h0000_3000;
  localparam logic [31:0] T2   = 32'h0000_3100;

  task automatic cyc(input logic uv, input logic [31:0] upc, input logic ut,
                     input logic [31:0] utg, input logic [31:0] lpc);
    @(posedge clk); #1;
    updValid = uv; updPc = upc; updTaken = ut; updTarget = utg; lookupPc = lpc;
  endtask

  task automatic want(input logic h, input logic t2, input logic t1,
                      input logic [31:0] tg, input string req);
    expItem_t it;
    it.hit = h; it.taken2 = t2; it.taken1 = t1; it.target = tg; it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: compare the lookup outputs of both instances mid-cycle
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (hit2 !== it.hit || tk2 !== it.taken2 || tgt2 !== it.target) begin
        fails++;
        $display("FAIL %s four-state: got hit=%b taken=%b target=%h, expected hit=%b taken=%b target=%h",
                 it.req, hit2, tk2, tgt2, it.hit, it.taken2, it.target);
      end
      checks++;
      if (hit1 !== it.hit || tk1 !== it.taken1 || tgt1 !== it.target) begin
        fails++;
        $display("FAIL %s two-state: got hit=%b taken=%b target=%h, expected hit=%b taken=%b target=%h",
                 it.req, hit1, tk1, tgt1, it.hit, it.taken1, it.target);
      end
    end
  end

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog: got no end of run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    cyc(0, '0, 0, '0, PC_A); want(0, 0, 0, '0, "R1");  // inside reset
    cyc(0, '0, 0, '0, PC_A); want(0, 0, 0, '0, "R1");
    @(posedge clk); #1 rstN = 1'b1;
    cyc(0, '0, 0, '0, PC_A); want(0, 0, 0, '0, "R3");
    // allocate A taken, same-cycle lookup still misses
    cyc(1, PC_A, 1, T1, PC_A); want(0, 0, 0, '0, "R8");
    cyc(0, '0, 0, '0, PC_A);   want(1, 1, 1, T1, "R6");
    // not-taken hit: state 2->1 / 1->0, target kept
    cyc(1, PC_A, 0, 32'h1048, PC_C); want(0, 0, 0, '0, "R2");
    cyc(0, '0, 0, '0, PC_A);         want(1, 0, 0, T1, "R7");
    // taken updates with a new target, climbing to saturation
    cyc(1, PC_A, 1, T2, PC_A); want(1, 0, 0, T1, "R8");
    cyc(1, PC_A, 1, T2, PC_A); want(1, 1, 1, T2, "R4");
    cyc(1, PC_A, 1, T2, PC_A); want(1, 1, 1, T2, "R4");
    // one not-taken from strong taken: four-state holds, two-state flips
    cyc(1, PC_A, 0, 32'h1048, PC_A); want(1, 1, 1, T2, "R4");
    cyc(0, '0, 0, '0, PC_A);         want(1, 1, 0, T2, "R4 R5");
    cyc(1, PC_A, 0, 32'h1048, PC_A); want(1, 1, 0, T2, "R4 R5");
    cyc(0, '0, 0, '0, PC_A);         want(1, 0, 0, T2, "R4");
    // bottom saturation, then a single taken outcome
    cyc(1, PC_A, 0, 32'h1048, PC_A); want(1, 0, 0, T2, "R4");
    cyc(1, PC_A, 1, T2, PC_A);       want(1, 0, 0, T2, "R4");
    cyc(0, '0, 0, '0, PC_A);         want(1, 0, 1, T2, "R4 R5");
    // alias at the same index
    cyc(0, '0, 0, '0, PC_B);                 want(0, 0, 0, '0, "R2");
    cyc(1, PC_B, 0, 32'h0000_5000, PC_B);    want(0, 0, 0, '0, "R8");
    cyc(0, '0, 0, '0, PC_B);                 want(1, 0, 0, 32'h0000_5000, "R6 R9");
    cyc(0, '0, 0, '0, PC_A);                 want(0, 0, 0, '0, "R9");
    // other index leaves B alone
    cyc(1, PC_C, 1, 32'h0000_6000, PC_B);    want(1, 0, 0, 32'h0000_5000, "R2");
    cyc(0, '0, 0, '0, PC_C);                 want(1, 1, 1, 32'h0000_6000, "R2");
    // not-taken hit with a different target keeps the stored one
    cyc(1, PC_B, 0, 32'h0000_7777, PC_B);    want(1, 0, 0, 32'h0000_5000, "R8");
    cyc(0, '0, 0, '0, PC_B);                 want(1, 0, 0, 32'h0000_5000, "R7");
    cyc(0, '0, 0, '0, PC_C);                 want(1, 1, 1, 32'h0000_6000, "R8");
    @(posedge clk); @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule